// File: doc/BRIEF.md
# Video Port Reset and Halt Controller

This block is the port-level control register and reset sequencer of a video capture and display peripheral. A single control register holds a self-clearing soft-reset bit, a halt bit, a display-mode bit and one function-select bit per group of I/O pins. The block drives the asynchronous reset for the rest of the port logic. It gates the pin output enables and the display clock enable, and it masks the DMA event requests raised by the channels.

Software brings the port up in a fixed order. While halt is set, it writes the mode and function-select bits. It then clears halt, which starts the port and locks the register. After that point only a soft reset can change the configuration. A soft reset takes the port back to the halted default state and leaves the external peripheral-enable input alone.

The bus side is a single-cycle strobe. Ready is returned exactly one cycle after every request, including during reset, so that a DMA engine never stalls.

Top module: `vport_ctrl`

## Requirements
- R1: After `rst_n` is asserted, a read returns halt=1 (bit 1), soft-reset=0 (bit 0), display mode=0 (bit 2) and function select=0 (bits 3 and up, one per pin group). `port_rst_n` is low while `rst_n` is low and for two clock edges after `rst_n` is released.
- R2: A register write with bit 0 set, accepted at edge E0, drives `port_rst_n` low right after E0. `port_rst_n` returns high after edge E0+3. Bit 0 reads back as 1 until that release and as 0 afterwards.
- R3: A soft reset returns halt to 1 and clears display mode and every function-select bit, whatever the same write carried in its other bits.
- R4: While halt is 1 and the port is out of reset, a write loads halt, display mode and function select from bits 1, 2 and 3 and up.
- R5: Once halt is 0, a write leaves halt, display mode and function select unchanged. Bit 0 of a write still starts a soft reset.
- R6: `bus_ready` is high in the cycle after each cycle in which `bus_sel` is high, both in reset and in normal operation. Writes that arrive while the port is in reset are discarded.
- R7: `dma_out` equals `dma_in` only when halt is 0 and the port is out of reset. Otherwise it is all zero.
- R8: Each bit of `pin_oe` equals the matching `gpio_oe` bit when the function-select bit of its group is 1, and is 0 otherwise. Pin i belongs to group i / GRP_W.
- R9: `dclk_oe` is 1 only when halt is 0, display mode is 1 and the port is out of reset.
- R10: `clk_en` is 1 whenever `per_en` is 1 or the port is in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous peripheral bus reset, active low |
| per_en | input | 1 | Peripheral enable from outside the port |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_wdata | input | NGRP+3 | Write data |
| bus_rdata | output | NGRP+3 | Read data, valid when bus_ready is high |
| bus_ready | output | 1 | Access acknowledge, one cycle after the strobe |
| port_rst_n | output | 1 | Reset for all port logic, active low |
| clk_en | output | 1 | Port clock enable |
| dma_in | input | NEV | Event requests from the channels |
| dma_out | output | NEV | Gated event requests |
| gpio_oe | input | NGRP*GRP_W | Output enables from the GPIO logic |
| pin_oe | output | NGRP*GRP_W | Pin output enables |
| dclk_oe | output | 1 | Display clock output enable |

## Verification
The bench builds the block with NGRP=3, GRP_W=4 and NEV=2. This gives a 6-bit control register and 12 pins. With three groups, the bench can enable one group, leave its neighbours off and confirm that the enable does not spill across group boundaries. Two event lines show that masking applies to every bit, not only the lowest. The small register width lets the bench write every field at once and prove that the lock holds all of them together.

// File: rtl/vport_ctrl.sv
module vport_ctrl #(
  parameter int NGRP  = 3,
  parameter int GRP_W = 4,
  parameter int NEV   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [NGRP+2:0]   bus_wdata,
  output logic [NGRP+2:0]   bus_rdata,
  output logic              bus_ready,
  output logic              port_rst_n,
  output logic              clk_en,
  input  logic [NEV-1:0]    dma_in,
  output logic [NEV-1:0]    dma_out,
  input  logic [NGRP*GRP_W-1:0] gpio_oe,
  output logic [NGRP*GRP_W-1:0] pin_oe,
  output logic              dclk_oe
);
  localparam int CW = NGRP + 3;

  logic            rst_q, halt_q, disp_q, kick_q;
  logic [NGRP-1:0] fsel_q;
  logic [1:0]      sync_q;
  logic            arst_n, in_rst, wr_ok;

  assign arst_n     = rst_n & ~kick_q;
  assign port_rst_n = sync_q[1];
  assign in_rst     = rst_q | ~port_rst_n;
  assign wr_ok      = bus_sel & bus_wr & ~in_rst;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q  <= 1'b0;
      halt_q <= 1'b1;
      disp_q <= 1'b0;
      fsel_q <= '0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      if (wr_ok && bus_wdata[0]) begin
        rst_q  <= 1'b1;
        kick_q <= 1'b1;
        halt_q <= 1'b1;
        disp_q <= 1'b0;
        fsel_q <= '0;
      end else begin
        if (rst_q && sync_q[0] && !sync_q[1]) rst_q <= 1'b0;
        if (wr_ok && halt_q) begin
          halt_q <= bus_wdata[1];
          disp_q <= bus_wdata[2];
          fsel_q <= bus_wdata[CW-1:3];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      if (bus_sel) bus_rdata <= {fsel_q, disp_q, halt_q, rst_q};
    end

  assign clk_en  = per_en | in_rst;
  assign dma_out = (halt_q | in_rst) ? '0 : dma_in;
  assign dclk_oe = ~halt_q & disp_q & ~in_rst;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign pin_oe[g*GRP_W +: GRP_W] = gpio_oe[g*GRP_W +: GRP_W] & {GRP_W{fsel_q[g]}};
  end
endmodule

module vport_ctrl_chk #(
  parameter int NGRP = 3,
  parameter int NEV  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            per_en,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [NGRP+2:0] bus_wdata,
  input logic            bus_ready,
  input logic            port_rst_n,
  input logic            clk_en,
  input logic [NEV-1:0]  dma_out,
  input logic            dclk_oe,
  input logic            rst_q,
  input logic            halt_q,
  input logic            disp_q,
  input logic [NGRP-1:0] fsel_q
);
  logic busy;
  assign busy = rst_q | ~port_rst_n;

  assert_ready_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);
  assert_soft_rst_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata[0] && !busy) |=> (!port_rst_n && rst_q && halt_q));
  assert_rst_bit_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_rst_n) |-> !rst_q);
  assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !busy && !(bus_sel && bus_wr && bus_wdata[0]))
      |=> (!halt_q && $stable(disp_q) && $stable(fsel_q)));
  assert_dma_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_out != '0) |-> (!halt_q && !busy));
  assert_dclk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_oe |-> (!halt_q && disp_q && port_rst_n));
  assert_clk_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || per_en) |-> clk_en);
endmodule

bind vport_ctrl vport_ctrl_chk #(.NGRP(NGRP), .NEV(NEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .per_en(per_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready), .port_rst_n(port_rst_n),
  .clk_en(clk_en), .dma_out(dma_out), .dclk_oe(dclk_oe), .rst_q(rst_q),
  .halt_q(halt_q), .disp_q(disp_q), .fsel_q(fsel_q)
);

// File: tb/vport_ctrl_bench.sv
module vport_ctrl_bench;
  localparam int NGRP = 3, GRP_W = 4, NEV = 2;
  localparam int CW = NGRP + 3, NP = NGRP * GRP_W;

  logic clk = 0, rst_n = 0, per_en = 0, bus_sel = 0, bus_wr = 0;
  logic [CW-1:0] bus_wdata = '0, bus_rdata;
  logic bus_ready, port_rst_n, clk_en, dclk_oe;
  logic [NEV-1:0] dma_in = '0, dma_out;
  logic [NP-1:0] gpio_oe = '0, pin_oe;
  int n_run = 0, n_fail = 0;
  logic [CW-1:0] rv;

  always #10 clk = ~clk;

  vport_ctrl #(.NGRP(NGRP), .GRP_W(GRP_W), .NEV(NEV)) u_vport_ctrl (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic access(logic wr, logic [CW-1:0] d, output logic [CW-1:0] r);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check("R6 ready", {31'b0, bus_ready}, 1);
    r = bus_rdata;
  endtask

  task automatic t_reset;
    rst_n = 0; per_en = 0;
    #35;
    check("R1 port reset low", {31'b0, port_rst_n}, 0);
    check("R10 clk_en in reset", {31'b0, clk_en}, 1);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 held after release", {31'b0, port_rst_n}, 0);
    @(negedge clk);
    check("R1 released", {31'b0, port_rst_n}, 1);
    check("R10 clk_en off", {31'b0, clk_en}, 0);
    access(0, '0, rv);
    check("R1 reset value", {26'b0, rv}, 32'h2);
  endtask

  task automatic t_config;
    dma_in = 2'b11; gpio_oe = 12'hFFF;
    access(1, {3'b010, 1'b1, 1'b1, 1'b0}, rv);
    access(0, '0, rv);
    check("R4 config loaded", {26'b0, rv}, {26'b0, 3'b010, 3'b110});
    check("R8 group1 only", {20'b0, pin_oe}, 32'h0F0);
    check("R7 dma masked halted", {30'b0, dma_out}, 0);
    check("R9 dclk off halted", {31'b0, dclk_oe}, 0);
    gpio_oe = 12'h5A5;
    #1 check("R8 follows gpio", {20'b0, pin_oe}, 32'h0A0);
  endtask

  task automatic t_run;
    access(1, {3'b010, 1'b1, 1'b0, 1'b0}, rv);
    check("R9 dclk on", {31'b0, dclk_oe}, 1);
    check("R7 dma passes", {30'b0, dma_out}, 2'b11);
    dma_in = 2'b10;
    #1 check("R7 dma bit1", {30'b0, dma_out}, 2'b10);
    access(1, {3'b101, 1'b0, 1'b1, 1'b0}, rv);
    access(0, '0, rv);
    check("R5 write locked", {26'b0, rv}, {26'b0, 3'b010, 3'b100});
    check("R8 unchanged after lock", {20'b0, pin_oe}, 32'h0A0);
  endtask

  task automatic t_soft;
    per_en = 0;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_wdata = {3'b111, 1'b1, 1'b0, 1'b1};
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check("R2 reset immediate", {31'b0, port_rst_n}, 0);
    check("R10 clk_en during soft reset", {31'b0, clk_en}, 1);
    check("R7 dma masked in reset", {30'b0, dma_out}, 0);
    bus_sel = 1; bus_wr = 0;
    @(negedge clk);
    bus_sel = 0;
    check("R6 ready in reset", {31'b0, bus_ready}, 1);
    check("R2 bit reads 1", {31'b0, bus_rdata[0]}, 1);
    check("R2 still low E1", {31'b0, port_rst_n}, 0);
    bus_sel = 1; bus_wr = 1; bus_wdata = 6'b111100;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check("R2 still low E2", {31'b0, port_rst_n}, 0);
    @(negedge clk);
    check("R2 released E3", {31'b0, port_rst_n}, 1);
    access(0, '0, rv);
    check("R3 defaults, R6 write dropped", {26'b0, rv}, 32'h2);
    check("R3 pins off", {20'b0, pin_oe}, 0);
    check("R9 dclk off after reset", {31'b0, dclk_oe}, 0);
    per_en = 1;
    #1 check("R10 per_en", {31'b0, clk_en}, 1);
  endtask

  initial begin
    t_reset;
    t_config;
    t_run;
    t_soft;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule